// File: doc/BRIEF.md
# Per-Frame Control/Status Register Port

This block sits behind a framed serial bus. Once per frame it receives one control byte, and two select bits inside that byte name which of three control registers the byte is written to. Each write lands in a staging (shadow) copy. The working copy of every control register is refreshed from its staging copy only at the frame boundary, so a setting never changes in the middle of a frame. Registers that were not addressed keep their contents.

Control register 1 drives four functions:
- It picks which of four status bytes goes out in the outgoing control slot.
- It carries a superframe alignment bit. A 1-to-0 change of this bit realigns a 96-frame wrapping counter.
- It can swap the two bearer channels between the system side and the line side.
- It can corrupt the outgoing checksum, so that error detection at the far end can be tested.

The bus shifting and the line coding are handled elsewhere. This block sees one byte per frame, plus a frame pulse that lasts one cycle.

Top module: `ctl_frame_port`

## Requirements
- R1: When `ctl_valid` is high, bits 1:0 of `ctl_byte` select the destination. 00 selects control register 1, 01 selects control register 2 and 10 selects control register 3. The whole byte is stored.
- R2: A byte whose bits 1:0 are 11 is ignored, and no control register changes.
- R3: Writing one control register leaves the other two unchanged.
- R4: A written value appears on `cr1_q`/`cr2_q`/`cr3_q` only after the next `frame_pulse`. Until then the previous value stays.
- R5: `stat_byte` is the status byte that bits 7:6 of the active control register 1 select. Code 00 selects byte 0 of `stat_regs` (bits 7:0), and code 11 selects byte 3 (bits 31:24).
- R6: `sf_count` advances by one on each `frame_pulse` and never changes otherwise. It wraps from 95 to 0.
- R7: At a frame pulse, if bit 5 of control register 1 goes from 1 (active) to 0 (newly written), `sf_count` is loaded with 0. When the counter is already aligned, a clear that is repeated every 96 frames leaves the count sequence unchanged.
- R8: `sf_start` is high for exactly the one cycle after a frame pulse that makes `sf_count` 0.
- R9: When bit 4 of the active control register 1 is set, B1 and B2 are swapped in both directions: system-to-line and line-to-system. When the bit is clear, they pass straight through.
- R10: When bit 3 of the active control register 1 is set, `crc_out` is the bitwise inverse of `crc_in`. Otherwise it equals `crc_in`.
- R11: Reset clears all three control registers and zeroes `sf_count` and `sf_start`. As a result, status byte 0 is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_pulse | input | 1 | One-cycle frame boundary strobe |
| ctl_valid | input | 1 | The incoming control byte is valid this cycle |
| ctl_byte | input | 8 | Incoming control byte; bits 1:0 select the register |
| stat_regs | input | 32 | Four status bytes; status byte n is at bits 8n+7:8n |
| stat_byte | output | 8 | Status byte chosen for the outgoing frame |
| cr1_q | output | 8 | Active control register 1 |
| cr2_q | output | 8 | Active control register 2 |
| cr3_q | output | 8 | Active control register 3 |
| sf_count | output | 7 | Superframe frame counter |
| sf_start | output | 1 | Superframe start strobe |
| sys_tx_b1 | input | 8 | B1 from the system side |
| sys_tx_b2 | input | 8 | B2 from the system side |
| line_tx_b1 | output | 8 | B1 toward the line |
| line_tx_b2 | output | 8 | B2 toward the line |
| line_rx_b1 | input | 8 | B1 from the line |
| line_rx_b2 | input | 8 | B2 from the line |
| sys_rx_b1 | output | 8 | B1 toward the system |
| sys_rx_b2 | output | 8 | B2 toward the system |
| crc_in | input | 6 | Computed checksum bits |
| crc_out | output | 6 | Checksum bits as transmitted |

## Verification
The hardest case to reach is the aligned periodic clear. The realigning 1-to-0 change must land on the very frame in which the counter would wrap anyway, and it must be shown to leave the count sequence untouched. The stimulus first forces an alignment in mid-count, and checks that alignment against a counter model in the bench. It then steps frames until the model reads 94, writes the sync bit high on that frame and low on the next, and checks that the count reads 0 and then 1, exactly as a free wrap would. A second clear, issued away from the wrap point, shows that the same write does move the count when the counter is not aligned.

// File: rtl/ctl_port_pkg.sv
package ctl_port_pkg;
   localparam int BYTE_W     = 8;
   localparam int SEL_LSB    = 0;
   localparam int STAT_LSB   = 6;
   localparam int SYNC_BIT   = 5;
   localparam int SWAP_BIT   = 4;
   localparam int CRCERR_BIT = 3;

   typedef enum logic [1:0] {
      DST_CR1  = 2'b00,
      DST_CR2  = 2'b01,
      DST_CR3  = 2'b10,
      DST_RSVD = 2'b11
   } ctl_dst_e;
endpackage

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
   import ctl_port_pkg::*;
#(
   parameter int NUM_CR = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_valid,
   input  logic [BYTE_W-1:0]             wr_byte,
   input  logic                          frame_pulse,
   output logic [NUM_CR-1:0][BYTE_W-1:0] act_q,
   output logic [BYTE_W-1:0]             stage_cr1
);
   logic [NUM_CR-1:0][BYTE_W-1:0] stage_q;

   if (NUM_CR < 1 || NUM_CR > 3) begin : g_bad_num
      $error("ctl_reg_bank: NUM_CR must be 1..3");
   end

   for (genvar gi = 0; gi < NUM_CR; gi++) begin : g_cr
      localparam logic [1:0] MY_SEL = 2'(gi);
      logic hit;
      assign hit = wr_valid && (wr_byte[SEL_LSB +: 2] == MY_SEL);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q[gi] <= '0;
         end else if (hit) begin
            stage_q[gi] <= wr_byte;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            act_q[gi] <= '0;
         end else if (frame_pulse) begin
            act_q[gi] <= stage_q[gi];
         end
      end

      // R3: a write aimed elsewhere leaves this staging register alone
      a_r3_other_held: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_valid && wr_byte[SEL_LSB +: 2] != MY_SEL) |=> $stable(stage_q[gi]));
   end

   assign stage_cr1 = stage_q[0];

   // R2: the reserved code writes nothing
   a_r2_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_byte[SEL_LSB +: 2] == DST_RSVD) |=> $stable(stage_q));

   // R4: active registers move only on a frame boundary
   a_r4_hold_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_pulse |=> $stable(act_q));
endmodule

// File: rtl/sf_counter.sv
module sf_counter #(
   parameter int SF_LEN = 96,
   localparam int CNT_W = $clog2(SF_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_pulse,
   input  logic             sync_act,
   input  logic             sync_next,
   output logic [CNT_W-1:0] count,
   output logic             sf_start
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(SF_LEN - 1);

   if (SF_LEN < 2) begin : g_bad_len
      $error("sf_counter: SF_LEN must be at least 2");
   end

   logic realign;
   logic [CNT_W-1:0] nxt;

   assign realign = sync_act && !sync_next;

   always_comb begin
      if (realign || count == LAST) nxt = '0;
      else                          nxt = count + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count    <= '0;
         sf_start <= 1'b0;
      end else begin
         sf_start <= frame_pulse && (nxt == '0);
         if (frame_pulse) count <= nxt;
      end
   end

   // R6: steady step, wrap and hold
   a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_pulse && !realign && count != LAST) |=> count == $past(count) + 1'b1);
   a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_pulse && count == LAST) |=> count == '0);
   a_r6_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_pulse |=> $stable(count));
   // R7: a falling sync bit realigns
   a_r7_realign: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_pulse && realign) |=> count == '0);
   // R8: strobe only on a zero count
   a_r8_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      sf_start |-> (count == '0 && $past(frame_pulse)));
endmodule

// File: rtl/bearer_path.sv
module bearer_path #(
   parameter int B_W   = 8,
   parameter int CRC_W = 6
) (
   input  logic             swap,
   input  logic             crc_corrupt,
   input  logic [B_W-1:0]   tx_a,
   input  logic [B_W-1:0]   tx_b,
   output logic [B_W-1:0]   tx_a_o,
   output logic [B_W-1:0]   tx_b_o,
   input  logic [B_W-1:0]   rx_a,
   input  logic [B_W-1:0]   rx_b,
   output logic [B_W-1:0]   rx_a_o,
   output logic [B_W-1:0]   rx_b_o,
   input  logic [CRC_W-1:0] crc_in,
   output logic [CRC_W-1:0] crc_out
);
   if (B_W < 1 || CRC_W < 1) begin : g_bad_w
      $error("bearer_path: widths must be positive");
   end

   always_comb begin
      tx_a_o = swap ? tx_b : tx_a;
      tx_b_o = swap ? tx_a : tx_b;
      rx_a_o = swap ? rx_b : rx_a;
      rx_b_o = swap ? rx_a : rx_b;
   end

   assign crc_out = crc_in ^ {CRC_W{crc_corrupt}};
endmodule

// File: rtl/ctl_frame_port.sv
module ctl_frame_port
   import ctl_port_pkg::*;
#(
   parameter int SF_LEN   = 96,
   parameter int B_W      = 8,
   parameter int CRC_W    = 6,
   parameter int NUM_STAT = 4,
   localparam int CNT_W   = $clog2(SF_LEN)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       frame_pulse,
   input  logic                       ctl_valid,
   input  logic [BYTE_W-1:0]          ctl_byte,
   input  logic [NUM_STAT*BYTE_W-1:0] stat_regs,
   output logic [BYTE_W-1:0]          stat_byte,
   output logic [BYTE_W-1:0]          cr1_q,
   output logic [BYTE_W-1:0]          cr2_q,
   output logic [BYTE_W-1:0]          cr3_q,
   output logic [CNT_W-1:0]           sf_count,
   output logic                       sf_start,
   input  logic [B_W-1:0]             sys_tx_b1,
   input  logic [B_W-1:0]             sys_tx_b2,
   output logic [B_W-1:0]             line_tx_b1,
   output logic [B_W-1:0]             line_tx_b2,
   input  logic [B_W-1:0]             line_rx_b1,
   input  logic [B_W-1:0]             line_rx_b2,
   output logic [B_W-1:0]             sys_rx_b1,
   output logic [B_W-1:0]             sys_rx_b2,
   input  logic [CRC_W-1:0]           crc_in,
   output logic [CRC_W-1:0]           crc_out
);
   localparam int NUM_CR = 3;

   if (NUM_STAT != 4) begin : g_bad_stat
      $error("ctl_frame_port: two select bits address exactly four status bytes");
   end

   logic [NUM_CR-1:0][BYTE_W-1:0] act;
   logic [BYTE_W-1:0]             stage1;
   logic [1:0]                    stat_sel;

   ctl_reg_bank #(.NUM_CR(NUM_CR)) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_valid    (ctl_valid),
      .wr_byte     (ctl_byte),
      .frame_pulse (frame_pulse),
      .act_q       (act),
      .stage_cr1   (stage1)
   );

   assign cr1_q    = act[0];
   assign cr2_q    = act[1];
   assign cr3_q    = act[2];
   assign stat_sel = cr1_q[STAT_LSB +: 2];
   assign stat_byte = stat_regs[stat_sel*BYTE_W +: BYTE_W];

   sf_counter #(.SF_LEN(SF_LEN)) u_sf (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_pulse (frame_pulse),
      .sync_act    (cr1_q[SYNC_BIT]),
      .sync_next   (stage1[SYNC_BIT]),
      .count       (sf_count),
      .sf_start    (sf_start)
   );

   bearer_path #(.B_W(B_W), .CRC_W(CRC_W)) u_path (
      .swap        (cr1_q[SWAP_BIT]),
      .crc_corrupt (cr1_q[CRCERR_BIT]),
      .tx_a        (sys_tx_b1),
      .tx_b        (sys_tx_b2),
      .tx_a_o      (line_tx_b1),
      .tx_b_o      (line_tx_b2),
      .rx_a        (line_rx_b1),
      .rx_b        (line_rx_b2),
      .rx_a_o      (sys_rx_b1),
      .rx_b_o      (sys_rx_b2),
      .crc_in      (crc_in),
      .crc_out     (crc_out)
   );
endmodule

// File: tb/test_ctl_frame_port.sv
module test_ctl_frame_port;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_pulse = 1'b0;
   logic ctl_valid = 1'b0;
   logic [7:0] ctl_byte = '0;
   logic [31:0] stat_regs = 32'h44_33_22_11;
   logic [7:0] stat_byte, cr1_q, cr2_q, cr3_q;
   logic [6:0] sf_count;
   logic sf_start;
   logic [7:0] sys_tx_b1 = 8'hA1, sys_tx_b2 = 8'hB2;
   logic [7:0] line_rx_b1 = 8'hC3, line_rx_b2 = 8'hD4;
   logic [7:0] line_tx_b1, line_tx_b2, sys_rx_b1, sys_rx_b2;
   logic [5:0] crc_in = 6'b101100;
   logic [5:0] crc_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;
   int m_cnt = 0;
   bit m_sync = 0;
   bit m_stage_sync = 0;

   always #5 clk = ~clk;

   ctl_frame_port i_ctl_frame_port (
      .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse),
      .ctl_valid(ctl_valid), .ctl_byte(ctl_byte), .stat_regs(stat_regs),
      .stat_byte(stat_byte), .cr1_q(cr1_q), .cr2_q(cr2_q), .cr3_q(cr3_q),
      .sf_count(sf_count), .sf_start(sf_start),
      .sys_tx_b1(sys_tx_b1), .sys_tx_b2(sys_tx_b2),
      .line_tx_b1(line_tx_b1), .line_tx_b2(line_tx_b2),
      .line_rx_b1(line_rx_b1), .line_rx_b2(line_rx_b2),
      .sys_rx_b1(sys_rx_b1), .sys_rx_b2(sys_rx_b2),
      .crc_in(crc_in), .crc_out(crc_out)
   );

   // {byte written, expected cr1, cr2, cr3 after the next frame pulse}
   localparam logic [31:0] VEC [9] = '{
      32'hC0_C0_00_00,  // R1 cr1
      32'h5D_C0_5D_00,  // R1 cr2
      32'hA6_C0_5D_A6,  // R1 cr3
      32'hFF_C0_5D_A6,  // R2 reserved
      32'h58_58_5D_A6,  // R3 cr1 only
      32'h31_58_31_A6,  // R3 cr2 only
      32'h03_58_31_A6,  // R2 reserved
      32'h82_58_31_82,  // R3 cr3 only
      32'h10_10_31_82   // R1 cr1 again
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] b);
      @(negedge clk);
      ctl_valid = 1'b1;
      ctl_byte  = b;
      @(negedge clk);
      ctl_valid = 1'b0;
      if (b[1:0] == 2'b00) m_stage_sync = b[5];
   endtask

   task automatic frame();
      @(negedge clk);
      frame_pulse = 1'b1;
      @(negedge clk);
      frame_pulse = 1'b0;
      if (m_sync && !m_stage_sync) m_cnt = 0;
      else m_cnt = (m_cnt == 95) ? 0 : m_cnt + 1;
      m_sync = m_stage_sync;
      chk("R6/R7 count", {25'd0, sf_count}, m_cnt);
      chk("R8 start", {31'd0, sf_start}, (m_cnt == 0) ? 1 : 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #2000000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] pc1, pc2, pc3;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 cr1", cr1_q, 0);
      chk("R11 cr2", cr2_q, 0);
      chk("R11 cr3", cr3_q, 0);
      chk("R11 count", sf_count, 0);
      chk("R11 start", sf_start, 0);
      chk("R11/R5 status", stat_byte, 8'h11);
      rst_n = 1'b1;
      pc1 = 0; pc2 = 0; pc3 = 0;

      for (int i = 0; i < 9; i++) begin
         wr(VEC[i][31:24]);
         repeat (2) @(negedge clk);
         chk("R4 held cr1", cr1_q, pc1);
         chk("R4 held cr2", cr2_q, pc2);
         chk("R4 held cr3", cr3_q, pc3);
         frame();
         chk("R1/R2/R3 cr1", cr1_q, VEC[i][23:16]);
         chk("R1/R2/R3 cr2", cr2_q, VEC[i][15:8]);
         chk("R1/R2/R3 cr3", cr3_q, VEC[i][7:0]);
         pc1 = VEC[i][23:16]; pc2 = VEC[i][15:8]; pc3 = VEC[i][7:0];
      end

      // R5 every status code
      for (int s = 0; s < 4; s++) begin
         wr({2'(s), 6'b000000});
         frame();
         chk("R5 status", stat_byte, stat_regs[s*8 +: 8]);
      end

      // R9 swap off then on
      chk("R9 straight tx1", line_tx_b1, 8'hA1);
      chk("R9 straight rx2", sys_rx_b2, 8'hD4);
      chk("R10 clean crc", crc_out, 6'b101100);
      wr(8'h18);
      frame();
      chk("R9 swap tx1", line_tx_b1, 8'hB2);
      chk("R9 swap tx2", line_tx_b2, 8'hA1);
      chk("R9 swap rx1", sys_rx_b1, 8'hD4);
      chk("R9 swap rx2", sys_rx_b2, 8'hC3);
      chk("R10 corrupt crc", crc_out, 6'b010011);
      wr(8'h00);
      frame();

      // R6 no pulse, no count
      repeat (7) @(negedge clk);
      chk("R6 idle count", sf_count, m_cnt);

      // R7 mid-count realignment
      wr(8'h20);
      frame();
      wr(8'h00);
      frame();
      chk("R7 realigned", sf_count, 0);
      // run a full superframe to see the wrap (R6, R8)
      for (int f = 0; f < 96; f++) frame();
      chk("R6 wrap", sf_count, 0);
      // R7 aligned periodic clear at the wrap point
      while (m_cnt != 94) frame();
      wr(8'h20);
      frame();
      chk("R7 before clear", sf_count, 95);
      wr(8'h00);
      frame();
      chk("R7 aligned clear", sf_count, 0);
      frame();
      chk("R7 undisturbed", sf_count, 1);
      // R7 clear away from the wrap point moves the count
      wr(8'h20);
      frame();
      wr(8'h00);
      frame();
      chk("R7 misaligned clear", sf_count, 0);

      finish_run();
   end
endmodule